// File: doc/BRIEF.md
# PCI Interrupt Line to Legacy IRQ Router

This block takes four active-low shared PCI interrupt lines (A, B, C, D) and steers each onto one of sixteen legacy IRQ outputs. Each line carries a 4-bit routing code. The codes sit two to a byte in two configuration bytes. The code space is sparse: only codes that name a usable legacy IRQ drive an output. All other codes leave the line disconnected.

A per-line mode bit selects how the line is presented. In the level-to-edge mode, a shared level interrupt produces a single one-cycle pulse when it is asserted. It can pulse again only after the line has been seen inactive. In the direct mode, the inverted line level goes straight to the chosen IRQ. Every line first passes through a two-flop synchronizer. The IRQ vector is registered. When several lines select the same IRQ, their contributions are ORed together.

The configuration bytes and mode bits are plain inputs, driven by a register block elsewhere in the chip. The IRQ vector feeds an interrupt controller, which is outside this block.

Top module: `pirq_router`

## Requirements
- R1: While `rst_n` is low, `irq_out` is all zero whatever the line inputs and configuration are.
- R2: A routing code of 3 to 7, 9 to 12, 14 or 15 selects the IRQ output whose index equals the code value.
- R3: Codes 0, 1, 2, 8 and 13 connect the line to nothing. Output bits 0, 1, 2, 8 and 13 are therefore never asserted, and no bit is asserted unless some line's code selects it.
- R4: Code fields are laid out as follows: line A in `route_ab[3:0]`, line B in `route_ab[7:4]`, line C in `route_cd[3:0]`, line D in `route_cd[7:4]`. Bit i of `mode_sel` and of `int_n` belongs to line i, with A as bit 0.
- R5: In level-to-edge mode (`mode_sel` bit = 0), take a line sampled low at clock edge k after being sampled high at edge k-1. Its selected IRQ is high for exactly the one cycle after edge k+2.
- R6: In level-to-edge mode, a line held low produces no further pulse. A new pulse needs at least one sampled high cycle in between.
- R7: In direct mode (`mode_sel` bit = 1), the selected IRQ follows the inverted line level. The value sampled at edge k appears after edge k+2.
- R8: Lines that select the same IRQ are ORed, in either mode and in mixed modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_n | input | 4 | Active-low interrupt lines, bit 0 = A .. bit 3 = D |
| route_ab | input | 8 | Routing codes: [3:0] line A, [7:4] line B |
| route_cd | input | 8 | Routing codes: [3:0] line C, [7:4] line D |
| mode_sel | input | 4 | Per-line mode: 0 = level-to-edge, 1 = direct |
| irq_out | output | 16 | Legacy IRQ vector, bit n = IRQn, active high |

## Verification
The assertions check four things on every cycle:
- the output stays quiet during reset;
- no output bit rises unless a line's code selected it in the previous cycle;
- every low-after-high sample in level-to-edge mode yields a converter pulse, and no converter pulse lasts two cycles;
- a held direct line keeps its IRQ up.

Three things can only be shown by the bench's scenarios:
- that each legal code selects exactly the IRQ whose index it names, and each reserved code selects none;
- that the four fields sit at their stated bit positions;
- that several lines, including a mix of pulsed and direct ones, OR onto one output with the stated latency.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int LINES  = 4;
    localparam int CODE_W = 4;
    localparam int IRQ_W  = 1 << CODE_W;

    typedef enum logic {
        MODE_TO_EDGE = 1'b0,
        MODE_DIRECT  = 1'b1
    } line_mode_e;

    // One-hot IRQ selected by a routing code; holes and zero select nothing.
    function automatic logic [IRQ_W-1:0] route_onehot(input logic [CODE_W-1:0] code);
        logic [IRQ_W-1:0] sel;
        sel = '0;
        if ((code >= 4'd3 && code <= 4'd7) ||
            (code >= 4'd9 && code <= 4'd12) ||
            (code >= 4'd14)) begin
            sel[code] = 1'b1;
        end
        return sel;
    endfunction

endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{RESET_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/pirq_edge.sv
module pirq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    output logic pulse_o
);

    typedef struct packed {
        logic seen;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.seen = act_i;
        pulse_o   = act_i & ~st_q.seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pirq_decode.sv
module pirq_decode
    import pirq_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [IRQ_W-1:0]  mask_o
);

    always_comb begin
        mask_o = route_onehot(code_i);
    end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] int_n,
    input  logic [7:0]       route_ab,
    input  logic [7:0]       route_cd,
    input  logic [LINES-1:0] mode_sel,
    output logic [IRQ_W-1:0] irq_out
);

    localparam int ROUTE_W = LINES * CODE_W;

    typedef struct packed {
        logic [IRQ_W-1:0] irq;
    } rtr_state_t;

    logic [ROUTE_W-1:0] route_all;
    logic [LINES-1:0]   sync_n;
    logic [LINES-1:0]   act;
    logic [LINES-1:0]   edge_pulse;
    logic [LINES-1:0]   contrib;
    logic [IRQ_W-1:0]   line_mask [LINES];
    rtr_state_t         st_d, st_q;

    assign route_all = {route_cd, route_ab};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        pirq_sync #(
            .STAGES    (SYNC_STAGES),
            .RESET_VAL (1'b1)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (int_n[g]),
            .q_o   (sync_n[g])
        );

        assign act[g] = ~sync_n[g];

        pirq_edge u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_i   (act[g]),
            .pulse_o (edge_pulse[g])
        );

        pirq_decode u_dec (
            .code_i (route_all[g*CODE_W +: CODE_W]),
            .mask_o (line_mask[g])
        );

        assign contrib[g] = (line_mode_e'(mode_sel[g]) == MODE_DIRECT) ? act[g] : edge_pulse[g];
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = '0;
        for (int i = 0; i < LINES; i++) begin
            if (contrib[i]) begin
                st_d.irq = st_d.irq | line_mask[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_out = st_q.irq;

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
    import pirq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] int_n,
    input logic [7:0]       route_ab,
    input logic [7:0]       route_cd,
    input logic [LINES-1:0] mode_sel,
    input logic [IRQ_W-1:0] irq_out,
    input logic [LINES-1:0] edge_pulse
);

    logic [1:0]       live_q;
    logic [IRQ_W-1:0] sel_mask [LINES];
    logic [IRQ_W-1:0] any_mask;
    logic             live_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (live_q != 2'd3) begin
            live_q <= live_q + 2'd1;
        end
    end

    assign live_ok = (live_q == 2'd3);

    always_comb begin
        any_mask = '0;
        for (int i = 0; i < LINES; i++) begin
            sel_mask[i] = route_onehot((i < 2) ? route_ab[(i%2)*CODE_W +: CODE_W]
                                               : route_cd[(i%2)*CODE_W +: CODE_W]);
            any_mask    = any_mask | sel_mask[i];
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> irq_out == '0);

    // R3
    a_r3_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~$past(any_mask)) == '0);

    for (genvar g = 0; g < LINES; g++) begin : g_chk
        // R5
        a_r5_edge_fires: assert property (@(posedge clk) disable iff (!rst_n)
            (live_ok && $past(int_n[g], 3) && !$past(int_n[g], 2)) |-> edge_pulse[g]);

        // R6
        a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            edge_pulse[g] |=> !edge_pulse[g]);

        // R7
        a_r7_direct_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (live_ok && $past(mode_sel[g]) && !$past(int_n[g], 3))
            |-> ((irq_out & $past(sel_mask[g])) == $past(sel_mask[g])));
    end

endmodule

bind pirq_router pirq_router_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_n      (int_n),
    .route_ab   (route_ab),
    .route_cd   (route_cd),
    .mode_sel   (mode_sel),
    .irq_out    (irq_out),
    .edge_pulse (edge_pulse)
);

// File: tb/pirq_router_tb_top.sv
module pirq_router_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  int_n;
    logic [7:0]  route_ab;
    logic [7:0]  route_cd;
    logic [3:0]  mode_sel;
    logic [15:0] irq_out;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [3:0]  p0, p1, p2, p3;

    always #10 clk = ~clk;

    pirq_router dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_n    (int_n),
        .route_ab (route_ab),
        .route_cd (route_cd),
        .mode_sel (mode_sel),
        .irq_out  (irq_out)
    );

    // R2 / R3 code table, written from the requirements
    function automatic logic [15:0] ref_map(input logic [3:0] c);
        case (c)
            4'd3, 4'd4, 4'd5, 4'd6, 4'd7,
            4'd9, 4'd10, 4'd11, 4'd12,
            4'd14, 4'd15: ref_map = 16'h1 << c;
            default:      ref_map = 16'h0;
        endcase
    endfunction

    function automatic logic [3:0] code_of(input int i);
        case (i)
            0:       code_of = route_ab[3:0];
            1:       code_of = route_ab[7:4];
            2:       code_of = route_cd[3:0];
            default: code_of = route_cd[7:4];
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: irq_out actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Driver: one clock, then push the expected vector for the output after that edge.
    task automatic tick(input string tag);
        logic [15:0] e;
        @(posedge clk);
        p3 = p2; p2 = p1; p1 = p0; p0 = int_n;
        #1;
        e = '0;
        for (int i = 0; i < 4; i++) begin
            logic a2, a3, c;
            a2 = ~p2[i];
            a3 = ~p3[i];
            c  = mode_sel[i] ? a2 : (a2 & ~a3);
            if (c) e = e | ref_map(code_of(i));
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic run(input string tag, input logic [3:0] v, input int n);
        int_n = v;
        for (int k = 0; k < n; k++) tick(tag);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [15:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, irq_out, e);
        end
    end

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        p0 = 4'hF; p1 = 4'hF; p2 = 4'hF; p3 = 4'hF;
        rst_n    = 1'b0;
        int_n    = 4'h0;
        route_ab = 8'h53;
        route_cd = 8'hE9;
        mode_sel = 4'hF;

        // R1: lines active and routed, reset held
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R1", irq_out, 16'h0);
        end
        int_n = 4'hF;
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 / R3: every code on line A, direct mode
        route_cd = 8'h00;
        mode_sel = 4'b0001;
        for (int c = 0; c < 16; c++) begin
            string t;
            route_ab = {4'h0, 4'(c)};
            t = (ref_map(4'(c)) != 0) ? "R2" : "R3";
            run(t, 4'hE, 4);
            run(t, 4'hF, 4);
        end

        // R3: reserved codes on every line, all active
        route_ab = 8'h21;
        route_cd = 8'hD8;
        run("R3", 4'h0, 5);
        run("R3", 4'hF, 4);

        // R4: field positions, one line at a time
        route_ab = 8'h53;
        route_cd = 8'hE9;
        mode_sel = 4'hF;
        for (int i = 0; i < 4; i++) begin
            run("R4", ~(4'b1 << i), 4);
            run("R4", 4'hF, 4);
        end

        // R5 / R6: level-to-edge conversion
        mode_sel = 4'h0;
        run("R5", 4'hE, 8);
        run("R5", 4'hF, 3);
        run("R6", 4'hE, 2);
        run("R6", 4'hF, 1);
        run("R6", 4'hE, 5);
        run("R6", 4'hF, 4);
        run("R5", 4'h0, 6);
        run("R5", 4'hF, 4);

        // R7: direct mode, held and toggled levels
        mode_sel = 4'hF;
        run("R7", 4'hB, 10);
        run("R7", 4'hF, 2);
        run("R7", 4'hB, 1);
        run("R7", 4'hF, 4);

        // R8: merging, mixed modes onto shared outputs
        route_ab = 8'hAA;
        route_cd = 8'hAB;
        mode_sel = 4'b0011;
        run("R8", 4'hE, 3);
        run("R8", 4'hC, 3);
        run("R8", 4'h4, 3);
        run("R8", 4'h0, 4);
        run("R8", 4'hF, 4);
        mode_sel = 4'b0000;
        run("R8", 4'hB, 3);
        run("R8", 4'h3, 3);
        run("R8", 4'hF, 4);

        @(negedge clk);
        #1;
        finish_run();
    end

endmodule